// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two floating-point operands, supplied as raw IEEE-754 bit patterns, and writes the boolean outcome into a bank of condition-code bits. A later branch or select stage reads those bits. The operands can be one single-precision pair, one double-precision pair, or a packed pair of single-precision lanes. One of sixteen predicate codes selects the relation.

The predicates fall into two halves of eight. The lower half is quiet. The upper half (codes 8 to 15) is signaling: it repeats the same eight relations but also flags any NaN input as an invalid operation. Within each half, bit 0 of the code decides whether an unordered comparison counts as true. Bits 2:1 pick the relation: none, equal, less, or less-or-equal.

An absolute-value option clears the sign bits before the compare. The invalid-operation flag is reported beside the result for a separate status unit. Trap policy is decided in that status unit, not here.

Top module: `fp_cmp_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, all condition bits, `invalid_o` and `done_o` are 0.
- R2: A compare accepted on `valid_in` at a clock edge produces its result one cycle later: `done_o` is 1 for exactly that cycle, and the condition bits and `invalid_o` change in that same cycle.
- R3: Predicate bits 2:1 select the relation: 0 = none (always false), 1 = equal, 2 = less than, 3 = less or equal. Bit 0 set makes an unordered comparison true. Bit 3 selects the signaling form. The codes in order are f, un, eq, ueq, olt, ult, ole, ule, sf, ngle, seq, ngl, lt, nge, le, ngt.
- R4: An operand is a NaN when its exponent is all ones and its fraction is nonzero. If either operand is a NaN the pair is unordered: ordered predicates give 0 and unordered predicates give 1.
- R5: A NaN whose most significant fraction bit is 0 is signaling. `invalid_o` is 1 when either operand is a signaling NaN, for every predicate. For codes 8 to 15 it is also 1 when either operand is any NaN. This holds for the always-false codes 0 and 8 as well, whose result bit is still 0.
- R6: +0 and -0 compare equal. Less-than is ordered correctly across signs and for negative pairs. Infinities and subnormals are ordered as ordinary values.
- R7: With `abs_in` set, bit 63 is cleared for double format, and bits 31 and 63 for single and paired format, on both operands before comparing.
- R8: `fmt_in` 0 compares `opa_in[31:0]` against `opb_in[31:0]` as single precision. 1 compares all 64 bits as double precision. 2 compares the low 32-bit lanes into bit `cc_sel_in` and the high lanes into bit `cc_sel_in`+1 modulo the bank size; `invalid_o` is then the OR of both lanes. 3 is reserved: `done_o` still pulses, but no condition bit changes and `invalid_o` stays 0.
- R9: Only the addressed condition bit (two bits for paired) may change. All other bits, and every bit in a cycle with no accepted compare, keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Accept a compare this cycle |
| fmt_in | input | 2 | Operand format: 0 single, 1 double, 2 paired single, 3 reserved |
| pred_in | input | 4 | Predicate code |
| abs_in | input | 1 | Clear sign bits before comparing |
| cc_sel_in | input | CCW | Target condition bit (low lane for paired) |
| opa_in | input | 64 | First operand bit pattern |
| opb_in | input | 64 | Second operand bit pattern |
| cc_o | output | NUM_CC | Condition-code bank |
| invalid_o | output | 1 | Invalid-operation flag for the result due this cycle |
| done_o | output | 1 | A result was written this cycle |

## Verification
Every result of this block is due exactly one clock edge after the compare is accepted. That covers the condition bits, the invalid flag and the done pulse; the reserved-format no-op follows the same timing. The bench drives each stimulus on a falling edge. On the next falling edge it first compares all three outputs against the values its model derived from the previous stimulus, then drives the next stimulus. Back-to-back compares and idle gaps are therefore both checked at the cycle the result is due. The model computes relations through real-number arithmetic rather than bit-level magnitude logic.

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit #(
  parameter int NUM_CC = 8,
  localparam int CCW = $clog2(NUM_CC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [1:0]        fmt_in,
  input  logic [3:0]        pred_in,
  input  logic              abs_in,
  input  logic [CCW-1:0]    cc_sel_in,
  input  logic [63:0]       opa_in,
  input  logic [63:0]       opb_in,
  output logic [NUM_CC-1:0] cc_o,
  output logic              invalid_o,
  output logic              done_o
);

  localparam logic [1:0] FMT_SGL  = 2'd0;
  localparam logic [1:0] FMT_DBL  = 2'd1;
  localparam logic [1:0] FMT_PAIR = 2'd2;
  localparam logic [1:0] FMT_NONE = 2'd3;

  // returns {result, invalid} for one lane
  function automatic logic [1:0] lane_eval(input logic [63:0] a, input logic [63:0] b,
                                           input logic dbl, input logic [3:0] p);
    logic        sa, sb, na, nb, qa, qb, unord, eqv, ltv, rel;
    logic [62:0] ma, mb;
    if (dbl) begin
      sa = a[63];  sb = b[63];
      ma = a[62:0]; mb = b[62:0];
      na = (&a[62:52]) && (|a[51:0]);
      nb = (&b[62:52]) && (|b[51:0]);
      qa = a[51];  qb = b[51];
    end else begin
      sa = a[31];  sb = b[31];
      ma = {32'd0, a[30:0]}; mb = {32'd0, b[30:0]};
      na = (&a[30:23]) && (|a[22:0]);
      nb = (&b[30:23]) && (|b[22:0]);
      qa = a[22];  qb = b[22];
    end
    unord = na | nb;
    eqv   = ((ma == mb) && (sa == sb)) || ((ma == '0) && (mb == '0));
    if ((ma == '0) && (mb == '0)) ltv = 1'b0;
    else if (sa != sb)            ltv = sa;
    else if (!sa)                 ltv = ma < mb;
    else                          ltv = ma > mb;
    case (p[2:1])
      2'd0:    rel = 1'b0;
      2'd1:    rel = eqv;
      2'd2:    rel = ltv;
      default: rel = ltv | eqv;
    endcase
    lane_eval[1] = unord ? p[0] : rel;
    lane_eval[0] = (na & ~qa) | (nb & ~qb) | (p[3] & unord);
  endfunction

  logic [63:0]       sign_clr, a_m, b_m;
  logic [1:0]        lane_lo, lane_hi;
  logic [CCW-1:0]    cc_hi_idx;
  logic              do_write;
  logic [NUM_CC-1:0] cc_nxt, cc_q;
  logic              inv_q, done_q;

  assign sign_clr  = (fmt_in == FMT_DBL) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF_7FFF_FFFF;
  assign a_m       = abs_in ? (opa_in & sign_clr) : opa_in;
  assign b_m       = abs_in ? (opb_in & sign_clr) : opb_in;
  assign lane_lo   = lane_eval(a_m, b_m, fmt_in == FMT_DBL, pred_in);
  assign lane_hi   = lane_eval({32'd0, a_m[63:32]}, {32'd0, b_m[63:32]}, 1'b0, pred_in);
  assign cc_hi_idx = cc_sel_in + CCW'(1);
  assign do_write  = valid_in && (fmt_in != FMT_NONE);

  always_comb begin
    cc_nxt = cc_q;
    if (do_write) begin
      cc_nxt[cc_sel_in] = lane_lo[1];
      if (fmt_in == FMT_PAIR) cc_nxt[cc_hi_idx] = lane_hi[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q   <= '0;
      inv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cc_q   <= cc_nxt;
      inv_q  <= do_write && (lane_lo[0] || ((fmt_in == FMT_PAIR) && lane_hi[0]));
      done_q <= valid_in;
    end
  end

  assign cc_o      = cc_q;
  assign invalid_o = inv_q;
  assign done_o    = done_q;

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> done_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(cc_o) && !done_o && !invalid_o));
  // R9
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_in != FMT_PAIR) |=> ($countones(cc_o ^ $past(cc_o)) <= 1));
  // R8
  reserved_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && fmt_in == FMT_NONE) |=> ($stable(cc_o) && !invalid_o));
  // R5
  invalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> done_o);

endmodule

// File: tb/fp_cmp_unit_bench.sv
module fp_cmp_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic [1:0]  fmt_in = '0;
  logic [3:0]  pred_in = '0;
  logic        abs_in = 1'b0;
  logic [2:0]  cc_sel_in = '0;
  logic [63:0] opa_in = '0, opb_in = '0;
  logic [7:0]  cc_o;
  logic        invalid_o, done_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] exp_cc = '0;
  logic       exp_inv = 1'b0, exp_done = 1'b0;
  string      exp_tag = "R1 reset";

  always #4 clk = ~clk;

  fp_cmp_unit #(.NUM_CC(8)) u_fp_cmp_unit (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt_in(fmt_in),
    .pred_in(pred_in), .abs_in(abs_in), .cc_sel_in(cc_sel_in),
    .opa_in(opa_in), .opb_in(opb_in), .cc_o(cc_o),
    .invalid_o(invalid_o), .done_o(done_o));

  function automatic real sp_to_real(input logic [31:0] x);
    int  e;
    real r;
    e = int'(x[30:23]);
    if (e == 0)        r = real'(x[22:0]) * (2.0 ** -149);
    else if (e == 255) r = $bitstoreal(64'h7FF0_0000_0000_0000);
    else               r = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -r : r;
  endfunction

  // {result, invalid}
  function automatic logic [1:0] ref_lane(input logic [63:0] a, input logic [63:0] b,
                                          input bit dbl, input int p, input bit ab);
    bit  nan_a, nan_b, sig_a, sig_b, u, e, l, r;
    real ra, rb;
    if (dbl) begin
      nan_a = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
      nan_b = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
      sig_a = nan_a && (a[51] == 1'b0);
      sig_b = nan_b && (b[51] == 1'b0);
      ra = $bitstoreal(a); rb = $bitstoreal(b);
    end else begin
      nan_a = (a[30:23] == 8'hFF) && (a[22:0] != 0);
      nan_b = (b[30:23] == 8'hFF) && (b[22:0] != 0);
      sig_a = nan_a && (a[22] == 1'b0);
      sig_b = nan_b && (b[22] == 1'b0);
      ra = sp_to_real(a[31:0]); rb = sp_to_real(b[31:0]);
    end
    if (ab) begin
      if (ra < 0.0) ra = -ra;
      if (rb < 0.0) rb = -rb;
    end
    u = nan_a || nan_b;
    e = !u && (ra == rb);
    l = !u && (ra < rb);
    case (p % 8)
      0: r = 0;
      1: r = u;
      2: r = e;
      3: r = u || e;
      4: r = l;
      5: r = u || l;
      6: r = l || e;
      default: r = u || l || e;
    endcase
    return {r, sig_a || sig_b || (p >= 8 && u)};
  endfunction

  task automatic check_out();
    n_cmp++;
    if (cc_o !== exp_cc) begin
      n_bad++;
      $display("FAIL %s cc actual %h expected %h", exp_tag, cc_o, exp_cc);
    end
    n_cmp++;
    if (invalid_o !== exp_inv) begin
      n_bad++;
      $display("FAIL %s invalid actual %b expected %b", exp_tag, invalid_o, exp_inv);
    end
    n_cmp++;
    if (done_o !== exp_done) begin
      n_bad++;
      $display("FAIL %s done actual %b expected %b", exp_tag, done_o, exp_done);
    end
  endtask

  task automatic op(input bit v, input int f, input int p, input bit ab, input int c,
                    input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [1:0] lo, hi;
    @(negedge clk);
    check_out();
    valid_in = v; fmt_in = 2'(f); pred_in = 4'(p); abs_in = ab;
    cc_sel_in = 3'(c); opa_in = a; opb_in = b;
    exp_tag  = tag;
    exp_done = v;
    exp_inv  = 1'b0;
    if (v && f != 3) begin
      lo = ref_lane(a, b, f == 1, p, ab);
      exp_cc[c % 8] = lo[1];
      exp_inv = lo[0];
      if (f == 2) begin
        hi = ref_lane({32'd0, a[63:32]}, {32'd0, b[63:32]}, 0, p, ab);
        exp_cc[(c + 1) % 8] = hi[1];
        exp_inv = lo[0] | hi[0];
      end
    end
  endtask

  logic [63:0] dv [16] = '{
    64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000,
    64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
    64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000,
    64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
    64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000,
    64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000,
    64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000,
    64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0000};
  logic [31:0] sv [16] = '{
    32'h3F80_0000, 32'h4000_0000,
    32'hC000_0000, 32'h3F80_0000,
    32'h8000_0000, 32'h0000_0000,
    32'h0000_0001, 32'h0000_0000,
    32'hC000_0000, 32'hBF80_0000,
    32'h7F80_0000, 32'h4000_0000,
    32'h7FC0_0000, 32'h3F80_0000,
    32'h3F80_0000, 32'h7F80_0001};

  initial begin
    repeat (3) begin
      @(negedge clk);
      check_out();
    end
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 16; p++)
        op(1, 1, p, 0, (p + k) % 8, dv[2*k], dv[2*k+1], "R3 R4 R5 R6 double");
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 16; p++)
        op(1, 0, p, 0, (p + k) % 8, {32'hDEAD_BEEF, sv[2*k]}, {32'h0BAD_F00D, sv[2*k+1]},
           "R3 R4 R5 R6 single");
    op(1, 1, 4, 0, 2, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R7 olt no abs");
    op(1, 1, 4, 1, 2, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R7 olt abs double");
    op(1, 1, 2, 1, 3, 64'hBFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, "R7 eq abs double");
    op(1, 0, 2, 1, 4, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, "R7 eq abs single");
    op(1, 2, 6, 1, 5, {32'hC000_0000, 32'hBF80_0000}, {32'h3F80_0000, 32'h3F80_0000}, "R7 ole abs paired");
    op(1, 2, 4, 0, 7, {32'h3F80_0000, 32'hBF80_0000}, {32'h4000_0000, 32'h3F80_0000}, "R8 paired wrap to bit 0");
    op(1, 2, 4, 0, 7, {32'h4000_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'hBF80_0000}, "R8 paired wrap clear");
    op(1, 2, 3, 0, 2, {32'h7FC0_0000, 32'h3F80_0000}, {32'h3F80_0000, 32'h4000_0000}, "R8 paired nan high lane");
    op(1, 2, 0, 0, 0, {32'h7F80_0001, 32'h3F80_0000}, {32'h3F80_0000, 32'h3F80_0000}, "R5 R8 paired snan invalid");
    op(1, 2, 9, 0, 4, {32'h3F80_0000, 32'h7FC0_0000}, {32'h3F80_0000, 32'h3F80_0000}, "R5 R8 paired ngle");
    op(1, 0, 1, 0, 6, 64'h0000_0000_7FC0_0000, 64'h0, "R4 set bit 6");
    op(1, 3, 0, 0, 6, 64'h7FF0_0000_0000_0001, 64'h7FF0_0000_0000_0001, "R8 reserved format no write");
    op(1, 3, 15, 1, 1, 64'h7FF0_0000_0000_0001, 64'h0, "R8 reserved format no invalid");
    for (int i = 0; i < 4; i++)
      op(0, 1, 1, 0, 6, 64'h7FF8_0000_0000_0000, 64'h0, "R9 idle hold");
    op(1, 1, 12, 0, 0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, "R2 R9 after idle");
    op(0, 0, 0, 0, 0, 64'h0, 64'h0, "R2 done drop");
    op(0, 0, 0, 0, 0, 64'h0, 64'h0, "R9 idle end");
    @(negedge clk);
    check_out();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R2 actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule